// File: doc/BRIEF.md
# Dual-Output Level Interrupt Router

This block collects thirty-two level-sensitive interrupt request lines and presents them to a processor as two separate interrupt outputs. Each request line is brought into the local clock domain through a two-flop synchronizer. The line then passes through a per-source enable mask and a per-source routing bit before it reaches the outputs. The routing bit picks which of the two outputs the source drives. The top bit of the enable mask is a master switch over both outputs.

Software uses a simple single-cycle register bus, with an address, write data, a write strobe and combinational read data. The enable mask is never written directly. One register sets the bits written as one, and a second register clears the bits written as one. Software can read the synchronized request lines unmasked. It can also read a masked pending view for each output, so an interrupt handler can find which source is calling. No request state is held in the block. A source that is masked, or whose request line drops, leaves the pending views straight away.

Top module: `dual_irq_router`

## Requirements
- R1: Each of the 32 request inputs passes through two flops. A change at an input shows in the raw status (byte offset 0x30) after the second rising clock edge, and not after the first.
- R2: Reading offset 0x34 or 0x38 returns the current enable mask. The routing register at offset 0x20 can be both written and read back.
- R3: A write to offset 0x34 sets each enable bit whose write data bit is 1. Enable bits whose write data bit is 0 keep their value.
- R4: A write to offset 0x38 clears each enable bit whose write data bit is 1. Writing all ones clears the whole mask.
- R5: Enable bit 31 is the master enable. While it is 0, the status words at 0x00 and 0x04 read zero, and both interrupt outputs are low from the next clock edge onward.
- R6: A routing bit of 0 sends its source to status word 0x00 and output irq0_o. A routing bit of 1 sends it to status word 0x04 and output irq1_o.
- R7: No pending state is latched. Clearing an enable bit removes that source from the status words in the cycle after the write edge. A request line that drops leaves the status words once the synchronizer has carried the drop through.
- R8: Each interrupt output is a registered OR of its status word. The output follows the status word one rising edge later.
- R9: The raw status reads the synchronized requests whatever the enable mask, the routing bits or the master enable hold.
- R10: Offsets that are not mapped read as zero, and writes to them change neither the mask nor the routing register.
- R11: After reset, the enable mask and the routing register are zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Level-sensitive interrupt request lines |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq0_o | output | 1 | Interrupt output for sources routed with bit 0 |
| irq1_o | output | 1 | Interrupt output for sources routed with bit 1 |

## Verification
The bench builds the block with its default parameters: 32 sources, an 8-bit address and two synchronizer stages. With 32 sources, bit 31 is both an ordinary source and the master enable, so the bench can show how the two roles interact, for example a mask that enables every source except bit 31. With two synchronizer stages, the bench can count exactly on which edge the raw status, the status words and the registered outputs each change after a request moves.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int unsigned OFS_STAT0 = 'h00;
  localparam int unsigned OFS_STAT1 = 'h04;
  localparam int unsigned OFS_ROUTE = 'h20;
  localparam int unsigned OFS_RAW   = 'h30;
  localparam int unsigned OFS_ENSET = 'h34;
  localparam int unsigned OFS_ENCLR = 'h38;
endpackage

// File: rtl/irqr_sync.sv
module irqr_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irqr_regs.sv
module irqr_regs #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          we_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  route_o
);
  import irqr_pkg::*;

  logic [W-1:0] en_q, en_d;
  logic [W-1:0] route_q, route_d;
  logic         hit_set, hit_clr, hit_route;
  logic         en_ce, route_ce;

  assign hit_set   = (addr_i == AW'(OFS_ENSET));
  assign hit_clr   = (addr_i == AW'(OFS_ENCLR));
  assign hit_route = (addr_i == AW'(OFS_ROUTE));

  always_comb begin
    en_ce    = we_i && (hit_set || hit_clr);
    route_ce = we_i && hit_route;
    en_d     = en_q;
    if (hit_set) en_d = en_q | wdata_i;
    if (hit_clr) en_d = en_q & ~wdata_i;
    route_d  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (route_ce) route_q <= route_d;
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;
endmodule

// File: rtl/irqr_route.sv
module irqr_route #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] route_i,
  output logic [W-1:0] stat0_o,
  output logic [W-1:0] stat1_o,
  output logic         irq0_o,
  output logic         irq1_o
);
  localparam int unsigned GBIT = W - 1;

  logic [W-1:0] live;
  logic         irq0_d, irq1_d, irq0_q, irq1_q;

  always_comb begin
    live    = en_i[GBIT] ? (raw_i & en_i) : '0;
    stat0_o = live & ~route_i;
    stat1_o = live & route_i;
    irq0_d  = |stat0_o;
    irq1_d  = |stat1_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
    end
  end

  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;
endmodule

// File: rtl/dual_irq_router.sv
module dual_irq_router #(
  parameter int unsigned W           = 32,
  parameter int unsigned AW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  req_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [W-1:0]  bus_wdata_i,
  input  logic          bus_we_i,
  output logic [W-1:0]  bus_rdata_o,
  output logic          irq0_o,
  output logic          irq1_o
);
  import irqr_pkg::*;

  logic [W-1:0] raw_q;
  logic [W-1:0] en_q;
  logic [W-1:0] type_q;
  logic [W-1:0] stat0, stat1;

  irqr_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (raw_q)
  );

  irqr_regs #(.W(W), .AW(AW)) regs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .we_i   (bus_we_i),
    .en_o   (en_q),
    .route_o(type_q)
  );

  irqr_route #(.W(W)) route_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_q),
    .en_i   (en_q),
    .route_i(type_q),
    .stat0_o(stat0),
    .stat1_o(stat1),
    .irq0_o (irq0_o),
    .irq1_o (irq1_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if      (bus_addr_i == AW'(OFS_STAT0)) bus_rdata_o = stat0;
    else if (bus_addr_i == AW'(OFS_STAT1)) bus_rdata_o = stat1;
    else if (bus_addr_i == AW'(OFS_ROUTE)) bus_rdata_o = type_q;
    else if (bus_addr_i == AW'(OFS_RAW))   bus_rdata_o = raw_q;
    else if (bus_addr_i == AW'(OFS_ENSET) ||
             bus_addr_i == AW'(OFS_ENCLR)) bus_rdata_o = en_q;
  end
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic          we_i,
  input logic [W-1:0]  rdata_i,
  input logic          irq0_i,
  input logic          irq1_i,
  input logic [W-1:0]  raw_i,
  input logic [W-1:0]  en_i,
  input logic [W-1:0]  type_i
);
  import irqr_pkg::*;

  logic mapped;
  assign mapped = addr_i == AW'(OFS_STAT0) || addr_i == AW'(OFS_STAT1) ||
                  addr_i == AW'(OFS_ROUTE) || addr_i == AW'(OFS_RAW)   ||
                  addr_i == AW'(OFS_ENSET) || addr_i == AW'(OFS_ENCLR);

  // R3
  enset_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_ENSET)) |=>
      ((en_i & $past(wdata_i)) == $past(wdata_i)) &&
      ((en_i & ~$past(wdata_i)) == ($past(en_i) & ~$past(wdata_i))));

  // R4
  enclr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_ENCLR)) |=> ((en_i & $past(wdata_i)) == '0));

  // R5
  master_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[W-1] |=> (!irq0_i && !irq1_i));

  // R5
  master_off_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i[W-1] && (addr_i == AW'(OFS_STAT0) || addr_i == AW'(OFS_STAT1)))
      |-> rdata_i == '0);

  // R7
  irq0_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_i |-> $past(en_i[W-1] && |(raw_i & en_i & ~type_i)));

  // R7
  irq1_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq1_i |-> $past(en_i[W-1] && |(raw_i & en_i & type_i)));

  // R9
  raw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_RAW)) |-> rdata_i == raw_i);

  // R10
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(en_i) && $stable(type_i)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_i == '0);
endmodule

bind dual_irq_router irqr_chk #(.W(W), .AW(AW)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (bus_addr_i),
  .wdata_i(bus_wdata_i),
  .we_i   (bus_we_i),
  .rdata_i(bus_rdata_o),
  .irq0_i (irq0_o),
  .irq1_i (irq1_o),
  .raw_i  (raw_q),
  .en_i   (en_q),
  .type_i (type_q)
);

// File: tb/dual_irq_router_tb_top.sv
module dual_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;

  localparam logic [31:0] V_REQ [NV] = '{32'hFFFF_FFFF, 32'h0000_0F00, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0000_0000};
  localparam logic [31:0] V_SET [NV] = '{32'h8000_00FF, 32'h8000_FF00, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_TYP [NV] = '{32'h0000_000F, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0F0F_0F0F, 32'h0000_0000};
  localparam logic [31:0] V_ST0 [NV] = '{32'h8000_00F0, 32'h0000_0000, 32'h0000_0000, 32'hA0A0_A0A0, 32'h0000_0000};
  localparam logic [31:0] V_ST1 [NV] = '{32'h0000_000F, 32'h0000_0F00, 32'h0000_0000, 32'h0505_0505, 32'h0000_0000};
  localparam logic [1:0]  V_IRQ [NV] = '{2'b11, 2'b10, 2'b00, 2'b11, 2'b00};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq0, irq1;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(8'h34, v); check("R11 mask after reset", v, 32'h0);
    rd(8'h20, v); check("R11 routing after reset", v, 32'h0);
    check("R11 irq outputs after reset", {30'h0, irq1, irq0}, 32'h0);

    // Table walk: R6, R5, R2, R9, R8
    for (int i = 0; i < NV; i++) begin
      wr(8'h38, 32'hFFFF_FFFF);
      wr(8'h20, V_TYP[i]);
      wr(8'h34, V_SET[i]);
      req = V_REQ[i];
      repeat (3) tick();
      rd(8'h00, v); check($sformatf("R6 status0 vec%0d", i), v, V_ST0[i]);
      rd(8'h04, v); check($sformatf("R6 status1 vec%0d", i), v, V_ST1[i]);
      rd(8'h30, v); check($sformatf("R9 raw vec%0d", i), v, V_REQ[i]);
      rd(8'h38, v); check($sformatf("R2 mask vec%0d", i), v, V_SET[i]);
      rd(8'h20, v); check($sformatf("R2 routing vec%0d", i), v, V_TYP[i]);
      check($sformatf("R8 outputs vec%0d", i), {30'h0, irq1, irq0}, {30'h0, V_IRQ[i]});
    end

    // R1 synchronizer latency, R8 output latency
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0);
    wr(8'h34, 32'hFFFF_FFFF);
    req = 32'h0;
    repeat (3) tick();
    req = 32'h0000_0008;
    tick();
    rd(8'h30, v); check("R1 raw after one edge", v, 32'h0);
    tick();
    rd(8'h30, v); check("R1 raw after two edges", v, 32'h8);
    rd(8'h00, v); check("R6 status0 follows raw", v, 32'h8);
    check("R8 irq0 not yet", {31'h0, irq0}, 32'h0);
    tick();
    check("R8 irq0 one edge after status", {31'h0, irq0}, 32'h1);

    // R7 clearing an enable removes source at once
    wr(8'h38, 32'h0000_0008);
    rd(8'h00, v); check("R7 status0 after clear", v, 32'h0);
    check("R8 irq0 still registered", {31'h0, irq0}, 32'h1);
    tick();
    check("R7 irq0 drops", {31'h0, irq0}, 32'h0);

    // R3 and R4 partial set and clear
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0000_0001);
    wr(8'h34, 32'h0000_0002);
    rd(8'h34, v); check("R3 set keeps other bits", v, 32'h3);
    wr(8'h38, 32'h0000_0001);
    rd(8'h38, v); check("R4 clear only written bits", v, 32'h2);

    // R10 unmapped offset
    wr(8'h20, 32'h0000_00F0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R10 unmapped reads zero", v, 32'h0);
    rd(8'h34, v); check("R10 mask untouched", v, 32'h2);
    rd(8'h20, v); check("R10 routing untouched", v, 32'hF0);

    // R5 master enable, R9 raw unaffected
    wr(8'h20, 32'h0000_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    req = 32'hFFFF_FFFF;
    repeat (3) tick();
    check("R6 both outputs active", {30'h0, irq1, irq0}, 32'h3);
    wr(8'h38, 32'h8000_0000);
    rd(8'h00, v); check("R5 status0 gated", v, 32'h0);
    rd(8'h04, v); check("R5 status1 gated", v, 32'h0);
    rd(8'h30, v); check("R9 raw ignores master", v, 32'hFFFF_FFFF);
    tick();
    check("R5 outputs low", {30'h0, irq1, irq0}, 32'h0);

    // R7 request drop
    wr(8'h34, 32'h8000_0000);
    tick();
    check("R7 outputs back", {30'h0, irq1, irq0}, 32'h3);
    req = 32'h0;
    repeat (2) tick();
    rd(8'h04, v); check("R7 status1 after drop", v, 32'h0);
    tick();
    check("R7 outputs after drop", {30'h0, irq1, irq0}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule